// File: doc/BRIEF.md
# Frame-Sync Standby and Power Controller

This block decides, from the frame-sync inputs alone, whether each half of a voice-band serial port is running, idle or held in a test state. It counts whole frames on the master clock. A frame is a fixed number of master-clock periods, 144 by default. When a sync input shows no high level for a run of complete frames, that channel drops into standby. When a sync input is stuck high for the same run, the block flags test mode. An active-low power-down input overrides everything.

A second, free-running reference clock watches the master clock. When master-clock activity stops for longer than a programmed number of reference cycles, the serial output enable is withdrawn at once. When the clock returns, the block runs the same output blanking interval that follows reset. That interval is a fixed number of frames during which the transmit serial drivers stay in high impedance.

The serial port uses `dout_en_o` to tristate its data output and its time-slot strobe. The other outputs are plain status flags for the rest of the chip.

Top module: `fsync_pwr_ctrl`

## Requirements
- R1: A channel goes to standby (its active flag low) once its sync input has been low for every cycle of IDLE_FRAMES (default 5) consecutive whole frames. Fewer than that many whole low frames leaves it active. Its inactivity count saturates at IDLE_FRAMES.
- R2: The transmit sync (`fsx_i`) controls only `tx_active_o`, and the receive sync (`fsr_i`) controls only `rx_active_o`. `standby_all_o` is high exactly when both channels are in standby and the block is neither powered down nor in test mode.
- R3: A sync input that is high for every cycle of IDLE_FRAMES consecutive whole frames sets `test_mode_o`. This drops both active flags and the output enable. A single low cycle on that sync clears its stuck count.
- R4: While `pdn_i` is low, `power_down_o` is high and every other output is low, whatever the sync inputs do. This includes a sync that is held high.
- R5: After reset, `dout_en_o` stays low for BLANK_FRAMES (default 4) frames of the master clock, then follows the transmit channel state.
- R6: If no master-clock activity is seen for LOSS_TIMEOUT reference-clock cycles, `dout_en_o` drops without needing a master-clock edge. After the clock returns, the BLANK_FRAMES blanking runs again before the enable can return.
- R7: `dout_en_o` is high only while the transmit channel is active. It stays high in receive-only standby and is low in transmit standby, full standby, test mode and power-down.
- R8: Any cycle with a sync input high clears that channel's inactivity count, so the channel is active again on the next cycle.
- R9: Leaving power-down restarts frame counting and the output blanking, so `dout_en_o` returns only after BLANK_FRAMES frames.
- R10: Directly after reset, with both syncs low, both channels read active, and test mode, standby, power-down and the output enable all read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; frames are counted on it |
| ref_clk_i | input | 1 | Free-running reference clock for clock-loss detection |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| fsx_i | input | 1 | Transmit frame sync |
| fsr_i | input | 1 | Receive frame sync |
| pdn_i | input | 1 | Power-down request, active low |
| tx_active_o | output | 1 | Transmit channel running |
| rx_active_o | output | 1 | Receive channel running |
| standby_all_o | output | 1 | Both channels in standby |
| test_mode_o | output | 1 | A sync input has been stuck high |
| power_down_o | output | 1 | Power-down in force |
| dout_en_o | output | 1 | Drive enable for serial data output and time-slot strobe |

## Verification
The bench places the end of a transmit-low stretch on both sides of the five-frame threshold. A counter that is off by one frame, or that counts partial frames, flips the active flag at the wrong check. It stops the master clock outright and checks that the enable falls while no master edge arrives. A design that detects loss only in the master domain keeps driving. After the clock returns, and again after power-down, it checks that the enable does not come back early, which is what a design that skips the re-blanking would do. It also drives a sync stuck high during power-down and checks that test mode stays low, which catches a wrong priority.

// File: rtl/fsync_pwr_pkg.sv
package fsync_pwr_pkg;
  typedef struct packed {
    logic idle;
    logic stuck;
  } chan_stat_t;

  localparam int unsigned NUM_CHAN = 2;
  localparam int unsigned CH_TX    = 0;
  localparam int unsigned CH_RX    = 1;
endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/fsp_chan_mon.sv
module fsp_chan_mon
  import fsync_pwr_pkg::*;
#(
  parameter int unsigned LIMIT = 5,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          frame_end_i,
  input  logic          fs_i,
  output chan_stat_t    stat_o,
  output logic [CW-1:0] low_cnt_o
);
  logic          seen_hi_q, seen_lo_q;
  logic [CW-1:0] low_cnt_q, hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
      low_cnt_q <= '0;
      hi_cnt_q  <= '0;
    end else if (clr_i) begin
      seen_hi_q <= 1'b0;
      seen_lo_q <= 1'b0;
      low_cnt_q <= '0;
      hi_cnt_q  <= '0;
    end else begin
      if (frame_end_i) begin
        seen_hi_q <= 1'b0;
        seen_lo_q <= 1'b0;
      end else begin
        seen_hi_q <= seen_hi_q | fs_i;
        seen_lo_q <= seen_lo_q | ~fs_i;
      end
      // whole frame low -> one more idle frame
      if (fs_i)
        low_cnt_q <= '0;
      else if (frame_end_i && !seen_hi_q && low_cnt_q != CW'(LIMIT))
        low_cnt_q <= low_cnt_q + 1'b1;
      // whole frame high -> one more stuck frame
      if (!fs_i)
        hi_cnt_q <= '0;
      else if (frame_end_i && !seen_lo_q && hi_cnt_q != CW'(LIMIT))
        hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign stat_o.idle  = (low_cnt_q == CW'(LIMIT));
  assign stat_o.stuck = (hi_cnt_q == CW'(LIMIT));
  assign low_cnt_o    = low_cnt_q;
endmodule

// File: rtl/fsp_clk_watch.sv
module fsp_clk_watch #(
  parameter int unsigned LOSS_TIMEOUT = 16,
  localparam int unsigned TW          = $clog2(LOSS_TIMEOUT + 1)
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  input  logic ack_i,
  output logic lost_o
);
  logic          tgl_s, tgl_prev_q, ack_s, lost_q;
  logic [TW-1:0] idle_cnt_q;
  logic          change;

  fsp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_tgl_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(tgl_i), .q_o(tgl_s)
  );
  fsp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_ack_sync (
    .clk_i(ref_clk_i), .rst_ni(rst_ni), .d_i(ack_i), .q_o(ack_s)
  );

  assign change = tgl_s ^ tgl_prev_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_prev_q <= 1'b0;
      idle_cnt_q <= '0;
      lost_q     <= 1'b0;
    end else begin
      tgl_prev_q <= tgl_s;
      if (change)                              idle_cnt_q <= '0;
      else if (idle_cnt_q != TW'(LOSS_TIMEOUT)) idle_cnt_q <= idle_cnt_q + 1'b1;
      // stays set until the master domain has seen it and restarted
      if (idle_cnt_q == TW'(LOSS_TIMEOUT)) lost_q <= 1'b1;
      else if (lost_q && ack_s)            lost_q <= 1'b0;
    end
  end

  assign lost_o = lost_q;
endmodule

// File: rtl/fsync_pwr_ctrl.sv
module fsync_pwr_ctrl
  import fsync_pwr_pkg::*;
#(
  parameter int unsigned FRAME_LEN    = 144,
  parameter int unsigned IDLE_FRAMES  = 5,
  parameter int unsigned BLANK_FRAMES = 4,
  parameter int unsigned LOSS_TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic fsx_i,
  input  logic fsr_i,
  input  logic pdn_i,
  output logic tx_active_o,
  output logic rx_active_o,
  output logic standby_all_o,
  output logic test_mode_o,
  output logic power_down_o,
  output logic dout_en_o
);
  localparam int unsigned FW = $clog2(FRAME_LEN);
  localparam int unsigned CW = $clog2(IDLE_FRAMES + 1);
  localparam int unsigned BW = $clog2(BLANK_FRAMES + 1);

  logic          pdn_s, pd, lost_ref, lost_s, restart;
  logic          tgl_q, seen_q;
  logic [FW-1:0] fcnt_q;
  logic [BW-1:0] blank_cnt_q;
  logic          frame_end, blank_done, any_stuck;
  logic [NUM_CHAN-1:0] fs_vec;
  chan_stat_t          stat [NUM_CHAN];
  logic [CW-1:0]       low_cnt [NUM_CHAN];

  fsp_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pdn_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pdn_i), .q_o(pdn_s)
  );
  fsp_sync #(.STAGES(2), .RST_VAL(1'b0)) u_lost_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lost_ref), .q_o(lost_s)
  );

  fsp_clk_watch #(.LOSS_TIMEOUT(LOSS_TIMEOUT)) u_watch (
    .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .tgl_i(tgl_q),
    .ack_i(seen_q), .lost_o(lost_ref)
  );

  assign pd      = ~pdn_s;
  assign restart = pd | lost_s;

  // activity toggle and loss acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      tgl_q  <= ~tgl_q;
      seen_q <= lost_s;
    end
  end

  assign frame_end = !restart && (fcnt_q == FW'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        fcnt_q <= '0;
    else if (restart)   fcnt_q <= '0;
    else if (frame_end) fcnt_q <= '0;
    else                fcnt_q <= fcnt_q + 1'b1;
  end

  assign blank_done = (blank_cnt_q == BW'(BLANK_FRAMES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       blank_cnt_q <= '0;
    else if (restart)                  blank_cnt_q <= '0;
    else if (frame_end && !blank_done) blank_cnt_q <= blank_cnt_q + 1'b1;
  end

  assign fs_vec[CH_TX] = fsx_i;
  assign fs_vec[CH_RX] = fsr_i;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    fsp_chan_mon #(.LIMIT(IDLE_FRAMES)) u_mon (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(restart),
      .frame_end_i(frame_end), .fs_i(fs_vec[g]),
      .stat_o(stat[g]), .low_cnt_o(low_cnt[g])
    );
  end

  assign any_stuck     = stat[CH_TX].stuck | stat[CH_RX].stuck;
  assign power_down_o  = pd;
  assign test_mode_o   = !pd && any_stuck;
  assign tx_active_o   = !pd && !any_stuck && !stat[CH_TX].idle;
  assign rx_active_o   = !pd && !any_stuck && !stat[CH_RX].idle;
  assign standby_all_o = !pd && !any_stuck && stat[CH_TX].idle && stat[CH_RX].idle;
  // lost_ref used directly so the enable falls with the master clock stopped
  assign dout_en_o     = tx_active_o && blank_done && !lost_s && !lost_ref;
endmodule

// File: rtl/fsync_pwr_ctrl_chk.sv
module fsync_pwr_ctrl_chk #(
  parameter int unsigned IDLE_FRAMES = 5,
  parameter int unsigned CW = 3,
  parameter int unsigned BW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fsx_i,
  input logic          restart,
  input logic [CW-1:0] tx_low_cnt,
  input logic [BW-1:0] blank_cnt,
  input logic          tx_active_o,
  input logic          rx_active_o,
  input logic          standby_all_o,
  input logic          test_mode_o,
  input logic          power_down_o,
  input logic          dout_en_o
);
  a_r1_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tx_low_cnt) <= int'(IDLE_FRAMES));

  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tx_low_cnt == '0 || tx_low_cnt == $past(tx_low_cnt) ||
              int'(tx_low_cnt) == int'($past(tx_low_cnt)) + 1));

  a_r8_rise_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsx_i |=> tx_low_cnt == '0);

  a_r2_standby_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_all_o |-> (!tx_active_o && !rx_active_o));

  a_r4_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |-> (!dout_en_o && !test_mode_o && !standby_all_o));

  a_r7_en_needs_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> tx_active_o);

  a_r9_restart_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> blank_cnt == '0);
endmodule

bind fsync_pwr_ctrl fsync_pwr_ctrl_chk #(
  .IDLE_FRAMES(IDLE_FRAMES), .CW(CW), .BW(BW)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .fsx_i(fsx_i), .restart(restart),
  .tx_low_cnt(low_cnt[0]), .blank_cnt(blank_cnt_q),
  .tx_active_o(tx_active_o), .rx_active_o(rx_active_o),
  .standby_all_o(standby_all_o), .test_mode_o(test_mode_o),
  .power_down_o(power_down_o), .dout_en_o(dout_en_o)
);

// File: tb/fsync_pwr_ctrl_tb.sv
module fsync_pwr_ctrl_tb_top;
  localparam int FL = 144;

  logic clk = 1'b0, ref_clk = 1'b0, clk_run = 1'b1;
  logic rst_n = 1'b0, fsx = 1'b0, fsr = 1'b0, pdn = 1'b1;
  logic tx_act, rx_act, sb_all, tmode, pdown, den;
  int   n_run = 0, n_fail = 0, bcnt = 0;
  logic done = 1'b0;

  always begin #10; if (clk_run) clk = ~clk; end
  always #15 ref_clk = ~ref_clk;

  fsync_pwr_ctrl dut_i (
    .clk_i(clk), .ref_clk_i(ref_clk), .rst_ni(rst_n),
    .fsx_i(fsx), .fsr_i(fsr), .pdn_i(pdn),
    .tx_active_o(tx_act), .rx_active_o(rx_act), .standby_all_o(sb_all),
    .test_mode_o(tmode), .power_down_o(pdown), .dout_en_o(den)
  );

  // pattern: 0 held low, 1 one-cycle pulse per frame, 2 held high
  // entry: {px[1:0], pr[1:0], pdn, tx, rx, sb, tm, pd, de}
  localparam logic [10:0] VEC [10] = '{
    {2'd1, 2'd1, 1'b1, 6'b110001},
    {2'd0, 2'd1, 1'b1, 6'b010000},
    {2'd1, 2'd0, 1'b1, 6'b100001},
    {2'd0, 2'd0, 1'b1, 6'b001000},
    {2'd2, 2'd1, 1'b1, 6'b000100},
    {2'd1, 2'd2, 1'b1, 6'b000100},
    {2'd1, 2'd1, 1'b1, 6'b110001},
    {2'd0, 2'd0, 1'b0, 6'b000010},
    {2'd2, 2'd2, 1'b0, 6'b000010},
    {2'd1, 2'd1, 1'b1, 6'b110001}
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic pat(input logic [1:0] p, input int b);
    case (p)
      2'd0: return 1'b0;
      2'd1: return (b % FL) == 0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run_cycles(input int n, input logic [1:0] px, input logic [1:0] pr);
    for (int i = 0; i < n; i++) begin
      fsx = pat(px, bcnt);
      fsr = pat(pr, bcnt);
      bcnt++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    run_cycles(2, 2'd0, 2'd0);
    chk("R10 tx_active", tx_act, 1'b1);
    chk("R10 rx_active", rx_act, 1'b1);
    chk("R10 dout_en", den, 1'b0);
    chk("R10 test_mode", tmode, 1'b0);
    chk("R10 power_down", pdown, 1'b0);
    chk("R10 standby_all", sb_all, 1'b0);
    // R5 blanking after reset: 4 frames = 576 edges
    bcnt = 0;
    run_cycles(530, 2'd1, 2'd1);
    chk("R5 blank still on", den, 1'b0);
    run_cycles(64, 2'd1, 2'd1);
    chk("R5 blank over", den, 1'b1);

    // table walk: R1 R2 R3 R4 R7 R9
    for (int v = 0; v < 10; v++) begin
      pdn = VEC[v][6];
      run_cycles(7 * FL, VEC[v][10:9], VEC[v][8:7]);
      chk($sformatf("R2 tx_active v%0d", v), tx_act, VEC[v][5]);
      chk($sformatf("R2 rx_active v%0d", v), rx_act, VEC[v][4]);
      chk($sformatf("R1 standby_all v%0d", v), sb_all, VEC[v][3]);
      chk($sformatf("R3 test_mode v%0d", v), tmode, VEC[v][2]);
      chk($sformatf("R4 power_down v%0d", v), pdown, VEC[v][1]);
      chk($sformatf("R7 dout_en v%0d", v), den, VEC[v][0]);
    end

    // R1 threshold: 4.5 frames low keeps tx active, 6.1 frames drops it
    run_cycles(4 * FL + FL / 2, 2'd0, 2'd1);
    chk("R1 below threshold", tx_act, 1'b1);
    run_cycles(FL + FL / 2 + 20, 2'd0, 2'd1);
    chk("R1 at threshold", tx_act, 1'b0);
    chk("R7 tx standby disables", den, 1'b0);

    // R8 one sync-high cycle returns the channel
    run_cycles(1, 2'd2, 2'd1);
    run_cycles(1, 2'd0, 2'd1);
    chk("R8 tx back", tx_act, 1'b1);
    chk("R8 dout_en back", den, 1'b1);
    bcnt = 1;
    run_cycles(2 * FL, 2'd1, 2'd1);

    // R6 clock loss
    clk_run = 1'b0;
    #3000;
    chk("R6 enable drops without clock", den, 1'b0);
    clk_run = 1'b1;
    @(negedge clk);
    run_cycles(2 * FL, 2'd1, 2'd1);
    chk("R6 reblank after clock return", den, 1'b0);
    chk("R6 tx still active", tx_act, 1'b1);
    run_cycles(4 * FL, 2'd1, 2'd1);
    chk("R6 enable after reblank", den, 1'b1);

    finish_run();
  end
endmodule